// File: doc/BRIEF.md
# Frame-Triggered ADC Channel Scanner

The block keeps a list of eight ADC command bytes and, whenever a start-of-frame tick arrives while the downstream frame buffer has room, walks the whole list in order through an attached ADC sequencer. It presents one command at a time with a single-cycle request and waits for a done strobe carrying the 16-bit result. Each result lands in its own slot of a 16-byte output frame: low byte first, then high byte. After the eighth result the frame is handed on with a single-cycle valid pulse.

The list is rewritten through a byte-wide command stream. A marker flags the first byte of each command, and that byte is an opcode. Opcode 0 loads the list from the bytes that follow and clears the digital-I/O mode flag, so later single reads return analog data again. Opcode 3 sets that flag. Ticks that arrive while the buffer is full are dropped, and so are ticks that arrive during a scan.

Top module: `adc_frame_scanner`

## Requirements
- R1: After reset, adc_req_o, frame_valid_o and dio_mode_o are 0, and list entry k holds the byte value k for k = 0..7.
- R2: A sof_i tick that arrives while idle with buf_full_i low raises adc_req_o in the next cycle. The scan then issues exactly 8 requests, and adc_cmd_o carries list entries 0..7 in that order.
- R3: The result of list entry k appears in frame_o bits [16k+15:16k]: byte 2k is the result's low byte and byte 2k+1 its high byte.
- R4: frame_valid_o is high for exactly one cycle, the cycle after the eighth adc_done_i. At that moment frame_o holds all eight results of the scan.
- R5: A sof_i tick that arrives while buf_full_i is high starts no request and produces no frame.
- R6: A sof_i tick that arrives while a scan is in progress has no effect: that frame still has exactly 8 requests and one frame_valid_o pulse.
- R7: A command with opcode 0x00 stores its next 8 data bytes into list entries 0..7 in order. Any further data bytes of that command are ignored.
- R8: Opcode 0x03 sets dio_mode_o in the next cycle. Opcode 0x00 clears it in the next cycle.
- R9: An opcode other than 0x00, and the data bytes that follow it, leave the list unchanged.
- R10: Only one request is outstanding at a time. adc_req_o is a single-cycle pulse and is not raised again until adc_done_i answers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-frame tick |
| buf_full_i | input | 1 | Downstream frame buffer still occupied |
| cmd_valid_i | input | 1 | Command byte valid |
| cmd_first_i | input | 1 | Marks the opcode byte of a command |
| cmd_data_i | input | 8 | Command byte |
| adc_req_o | output | 1 | Single-cycle conversion request |
| adc_cmd_o | output | 8 | Command byte for the current conversion |
| adc_done_i | input | 1 | Conversion finished, result valid |
| adc_data_i | input | 16 | Conversion result |
| frame_valid_o | output | 1 | Single-cycle frame-complete pulse |
| frame_o | output | 128 | Packed frame, byte j at bits [8j+7:8j] |
| dio_mode_o | output | 1 | Digital-I/O mode flag |

## Verification
The assertions assume that the ADC sequencer raises adc_done_i only once for each request, and only after that request. The bench's sequencer model ensures this by answering each logged request exactly once, after a latency it sets to between 1 and 4 cycles. The assertions also take cmd_first_i as marking opcode bytes only. The stimulus meets this by sending every command as one flagged opcode byte followed by unflagged data bytes, each held for one cycle.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2
  } scan_state_e;

  localparam logic [7:0] OP_LOAD_LIST = 8'h00;
  localparam logic [7:0] OP_SET_DIO   = 8'h03;
endpackage

// File: rtl/adc_cmd_decoder.sv
module adc_cmd_decoder #(
  parameter int N_CH  = 8,
  parameter int CMD_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cmd_valid_i,
  input  logic                        cmd_first_i,
  input  logic [CMD_W-1:0]            cmd_data_i,
  output logic [N_CH-1:0][CMD_W-1:0]  list_o,
  output logic                        dio_mode_o
);
  import adc_scan_pkg::*;
  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [N_CH-1:0][CMD_W-1:0] list_q;
  logic [IDX_W-1:0]           wr_idx_q;
  logic                       loading_q;
  logic                       dio_q;

  wire op_byte   = cmd_valid_i && cmd_first_i;
  wire data_byte = cmd_valid_i && !cmd_first_i && loading_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loading_q <= 1'b0;
      wr_idx_q  <= '0;
      dio_q     <= 1'b0;
    end else if (op_byte) begin
      loading_q <= (cmd_data_i == OP_LOAD_LIST);
      wr_idx_q  <= '0;
      if (cmd_data_i == OP_LOAD_LIST) dio_q <= 1'b0;
      else if (cmd_data_i == OP_SET_DIO) dio_q <= 1'b1;
    end else if (data_byte) begin
      wr_idx_q <= wr_idx_q + 1'b1;
      if (wr_idx_q == IDX_W'(N_CH - 1)) loading_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) list_q[k] <= CMD_W'(k);
      else if (data_byte && wr_idx_q == IDX_W'(k)) list_q[k] <= cmd_data_i;
    end
  end

  assign list_o     = list_q;
  assign dio_mode_o = dio_q;
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int N_CH = 8
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic                                         sof_i,
  input  logic                                         buf_full_i,
  input  logic                                         adc_done_i,
  output logic                                         adc_req_o,
  output logic [((N_CH > 1) ? $clog2(N_CH) : 1)-1:0]   idx_o,
  output logic                                         wr_o,
  output logic                                         busy_o,
  output logic                                         frame_valid_o
);
  import adc_scan_pkg::*;
  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  scan_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             valid_q, valid_d;

  wire last = (idx_q == IDX_W'(N_CH - 1));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    valid_d = 1'b0;
    unique case (state_q)
      S_IDLE: if (sof_i && !buf_full_i) begin
        state_d = S_REQ;
        idx_d   = '0;
      end
      S_REQ: state_d = S_WAIT;
      S_WAIT: if (adc_done_i) begin
        if (last) begin
          state_d = S_IDLE;
          valid_d = 1'b1;
        end else begin
          state_d = S_REQ;
          idx_d   = idx_q + 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      valid_q <= valid_d;
    end
  end

  assign adc_req_o     = (state_q == S_REQ);
  assign wr_o          = (state_q == S_WAIT) && adc_done_i;
  assign busy_o        = (state_q != S_IDLE);
  assign idx_o         = idx_q;
  assign frame_valid_o = valid_q;
endmodule

// File: rtl/adc_frame_packer.sv
module adc_frame_packer #(
  parameter int N_CH  = 8,
  parameter int RES_W = 16
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic                                        wr_i,
  input  logic [((N_CH > 1) ? $clog2(N_CH) : 1)-1:0]  idx_i,
  input  logic [RES_W-1:0]                            data_i,
  output logic [N_CH*RES_W-1:0]                       frame_o
);
  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  // slot k: low byte at the lower address
  for (genvar k = 0; k < N_CH; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) frame_o[k*RES_W +: RES_W] <= '0;
      else if (wr_i && idx_i == IDX_W'(k)) frame_o[k*RES_W +: RES_W] <= data_i;
    end
  end
endmodule

// File: rtl/adc_frame_scanner.sv
module adc_frame_scanner #(
  parameter int N_CH  = 8,
  parameter int CMD_W = 8,
  parameter int RES_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sof_i,
  input  logic                    buf_full_i,
  input  logic                    cmd_valid_i,
  input  logic                    cmd_first_i,
  input  logic [CMD_W-1:0]        cmd_data_i,
  output logic                    adc_req_o,
  output logic [CMD_W-1:0]        adc_cmd_o,
  input  logic                    adc_done_i,
  input  logic [RES_W-1:0]        adc_data_i,
  output logic                    frame_valid_o,
  output logic [N_CH*RES_W-1:0]   frame_o,
  output logic                    dio_mode_o
);
  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [N_CH-1:0][CMD_W-1:0] list;
  logic [IDX_W-1:0]           idx;
  logic                       wr;
  logic                       busy;

  adc_cmd_decoder #(.N_CH(N_CH), .CMD_W(CMD_W)) u_dec (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_first_i, .cmd_data_i,
    .list_o(list), .dio_mode_o
  );

  adc_scan_ctrl #(.N_CH(N_CH)) u_ctrl (
    .clk_i, .rst_ni, .sof_i, .buf_full_i, .adc_done_i, .adc_req_o,
    .idx_o(idx), .wr_o(wr), .busy_o(busy), .frame_valid_o
  );

  adc_frame_packer #(.N_CH(N_CH), .RES_W(RES_W)) u_pack (
    .clk_i, .rst_ni, .wr_i(wr), .idx_i(idx), .data_i(adc_data_i), .frame_o
  );

  assign adc_cmd_o = list[idx];
endmodule

// File: rtl/adc_frame_scanner_chk.sv
module adc_frame_scanner_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sof_i,
  input logic       buf_full_i,
  input logic       cmd_valid_i,
  input logic       cmd_first_i,
  input logic [7:0] cmd_data_i,
  input logic       adc_req_o,
  input logic       adc_done_i,
  input logic       frame_valid_o,
  input logic       dio_mode_o,
  input logic       busy
);
  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && sof_i && !buf_full_i) |=> adc_req_o);
  a_r5_full_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && sof_i && buf_full_i) |=> !adc_req_o);
  a_r4_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);
  a_r4_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_valid_o) |-> $past(adc_done_i));
  a_r10_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_o |=> !adc_req_o);
  a_r8_dio_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_first_i && cmd_data_i == 8'h03) |=> dio_mode_o);
  a_r8_dio_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_first_i && cmd_data_i == 8'h00) |=> !dio_mode_o);
endmodule

bind adc_frame_scanner adc_frame_scanner_chk u_chk (
  .clk_i, .rst_ni, .sof_i, .buf_full_i, .cmd_valid_i, .cmd_first_i,
  .cmd_data_i(cmd_data_i[7:0]), .adc_req_o, .adc_done_i, .frame_valid_o,
  .dio_mode_o, .busy(busy)
);

// File: tb/adc_frame_scanner_test.sv
module adc_frame_scanner_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         sof_i = 1'b0, buf_full_i = 1'b0;
  logic         cmd_valid_i = 1'b0, cmd_first_i = 1'b0;
  logic [7:0]   cmd_data_i = '0;
  logic         adc_req_o, adc_done_i = 1'b0;
  logic [7:0]   adc_cmd_o;
  logic [15:0]  adc_data_i = '0;
  logic         frame_valid_o, dio_mode_o;
  logic [127:0] frame_o;

  adc_frame_scanner uut (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] lst [8];
  logic [7:0] req_log [1024];
  int req_cnt = 0, frame_cnt = 0, lat = 1, wait_cnt = 0;
  logic [7:0] pend_cmd = '0, seed = 8'h3c;
  logic [127:0] snap = '0;
  logic prev_valid = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] res_of(input logic [7:0] c, input logic [7:0] s);
    return {c ^ s, c + 8'h11};
  endfunction

  // sequencer model and frame monitor
  initial forever begin
    @(negedge clk_i);
    if (!rst_ni) continue;
    adc_done_i = 1'b0;
    if (wait_cnt > 0) begin
      wait_cnt--;
      if (wait_cnt == 0) begin
        adc_done_i = 1'b1;
        adc_data_i = res_of(pend_cmd, seed);
      end
    end
    if (adc_req_o) begin
      if (wait_cnt != 0 || adc_done_i) chk(0, "R10 request while outstanding", 1, 0);
      if (req_cnt < 1024) req_log[req_cnt] = adc_cmd_o;
      req_cnt++;
      pend_cmd = adc_cmd_o;
      wait_cnt = lat;
    end
    if (frame_valid_o) begin
      frame_cnt++;
      snap = frame_o;
      if (prev_valid) chk(0, "R4 valid wider than one cycle", 2, 1);
      if (req_cnt % 8 != 0) chk(0, "R4 valid before 8 requests", req_cnt % 8, 0);
    end
    prev_valid = frame_valid_o;
  end

  task automatic send(input bit first, input logic [7:0] b);
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_first_i = first; cmd_data_i = b;
    @(negedge clk_i);
    cmd_valid_i = 1'b0; cmd_first_i = 1'b0;
  endtask

  task automatic pulse_sof();
    @(negedge clk_i); sof_i = 1'b1;
    @(negedge clk_i); sof_i = 1'b0;
  endtask

  task automatic run_frame(input string tag);
    int r0, f0;
    r0 = req_cnt; f0 = frame_cnt;
    pulse_sof();
    for (int t = 0; t < 300 && frame_cnt == f0; t++) @(negedge clk_i);
    repeat (10) @(negedge clk_i);
    chk(frame_cnt == f0 + 1, {tag, " R4 one frame"}, frame_cnt - f0, 1);
    chk(req_cnt == r0 + 8, {tag, " R2 eight requests"}, req_cnt - r0, 8);
    for (int k = 0; k < 8; k++) begin
      chk(req_log[r0 + k] == lst[k], {tag, " R2 order"}, req_log[r0 + k], lst[k]);
      chk(snap[16*k +: 16] == res_of(lst[k], seed), {tag, " R3 slot"},
          snap[16*k +: 16], res_of(lst[k], seed));
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk_i);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) lst[k] = 8'(k);
    repeat (3) @(negedge clk_i);
    chk(adc_req_o == 0, "R1 req at reset", adc_req_o, 0);
    chk(frame_valid_o == 0, "R1 valid at reset", frame_valid_o, 0);
    chk(dio_mode_o == 0, "R1 dio at reset", dio_mode_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    run_frame("R1 default list");

    // R5: buffer full drops the tick
    begin
      int r0, f0;
      r0 = req_cnt; f0 = frame_cnt;
      buf_full_i = 1'b1;
      pulse_sof();
      repeat (40) @(negedge clk_i);
      chk(req_cnt == r0, "R5 no request when full", req_cnt - r0, 0);
      chk(frame_cnt == f0, "R5 no frame when full", frame_cnt - f0, 0);
      buf_full_i = 1'b0;
    end

    // R8: dio flag set then cleared by a load
    send(1, 8'h03);
    chk(dio_mode_o == 1, "R8 dio set", dio_mode_o, 1);

    // R7: load 8 entries plus an extra ignored byte
    send(1, 8'h00);
    chk(dio_mode_o == 0, "R8 dio cleared by load", dio_mode_o, 0);
    for (int k = 0; k < 8; k++) begin
      lst[k] = 8'(8'h81 + 8'(k * 13));
      send(0, lst[k]);
    end
    send(0, 8'hEE);
    run_frame("R7 loaded list");

    // R9: other opcode and its data bytes change nothing
    send(1, 8'h05);
    for (int k = 0; k < 9; k++) send(0, 8'(8'hC0 + k));
    send(1, 8'h03);
    for (int k = 0; k < 3; k++) send(0, 8'h55);
    run_frame("R9 list unchanged");

    // R6: tick during a scan is dropped
    begin
      int r0, f0;
      r0 = req_cnt; f0 = frame_cnt;
      lat = 3;
      pulse_sof();
      repeat (5) @(negedge clk_i);
      pulse_sof();
      repeat (150) @(negedge clk_i);
      chk(req_cnt == r0 + 8, "R6 requests with extra tick", req_cnt - r0, 8);
      chk(frame_cnt == f0 + 1, "R6 frames with extra tick", frame_cnt - f0, 1);
    end

    // sweep latencies and list contents
    for (int f = 0; f < 12; f++) begin
      lat = 1 + (f % 4);
      seed = 8'(f * 29 + 7);
      send(1, 8'h00);
      for (int k = 0; k < 8; k++) begin
        lst[k] = 8'(k * 37 + f * 11 + 1);
        send(0, lst[k]);
      end
      run_frame("R3 sweep");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule